// File: doc/BRIEF.md
# USB Buffer Descriptor Status Writeback

This block holds one four-byte endpoint buffer descriptor and performs the status writeback that returns it to firmware once a USB transaction ends. Firmware loads a status byte, a count byte and a 16-bit buffer start address, and sets the ownership bit to hand the descriptor to the serial engine. While the engine owns it, the middle status bits carry firmware settings. The block decodes them into keep, no-increment, toggle-synchronisation and stall flags, along with the expected data-toggle value.

When the engine reports a finished transaction, the block takes the direction, the token PID and the number of bytes actually moved. For transmit (IN) and for accepted receive (OUT or SETUP), it writes the PID and the 10-bit moved count back into the descriptor. In the same cycle it clears ownership and raises a one-cycle completion pulse. A receive packet longer than the programmed count is refused instead. The block raises a NAK pulse, leaves the descriptor unchanged and keeps ownership with the engine, so the host can retry. The buffer address is carried through without any range check.

Top module: `bd_status_writeback`

## Requirements
- R1: After reset, status, count and address read 0, ownership (`bdOwned`, status bit 7) is 0, and `wbDone` and `nakOut` are low.
- R2: When `descLoad` is high at a clock edge, the three descriptor fields take the input values and are visible from the next cycle. A load takes priority over a completion in the same cycle.
- R3: When an accepted completion arrives while the descriptor is owned, the following happens in the same edge: status bit 7 clears, the token PID is written to status bits 5:2, and `wbDone` is high for exactly that one following cycle.
- R4: Status bit 6 is never altered by a writeback.
- R5: The 10-bit count is split across two bytes. Bits 9:8 are status bits 1:0 and bits 7:0 are the count byte. The written-back count is bits 9:0 of `xferBytes`.
- R6: Direction code 01 (IN) always completes, and the count field becomes the number of bytes sent.
- R7: Direction codes 00 (OUT) and 10 (SETUP) complete when `xferBytes` is at most the programmed 10-bit count, including the equal case. The count field then becomes the number of bytes received.
- R8: For OUT or SETUP, when `xferBytes` (11 bits) exceeds the programmed count, `nakOut` pulses for one cycle. The descriptor, including ownership, is unchanged and `wbDone` stays low.
- R9: A completion while ownership is 0, or with direction code 11, changes nothing and raises no pulse.
- R10: While owned, the settings are decoded as follows: `cfgKeep` = status bit 5, `cfgNoInc` = bit 4, `cfgSync` = bit 3, `cfgStall` = bit 2. All four read 0 when not owned.
- R11: `cfgToggleExp` equals status bit 6 only while owned with `cfgSync` set; otherwise it reads 0.
- R12: `bdAddr` returns the loaded address unchanged for any value, inside or outside any RAM window, across writebacks and NAKs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| descLoad | input | 1 | Firmware descriptor load strobe |
| descStatIn | input | 8 | Status byte to load |
| descCntIn | input | 8 | Count byte to load |
| descAddrIn | input | 16 | Buffer start address to load |
| xferDone | input | 1 | Transaction-complete strobe from the serial engine |
| xferDir | input | 2 | 00 OUT, 01 IN, 10 SETUP, 11 reserved |
| xferPid | input | 4 | Token PID of the transaction |
| xferBytes | input | 11 | Bytes actually moved |
| bdStat | output | 8 | Current status byte |
| bdCnt | output | 8 | Current count byte |
| bdAddr | output | 16 | Current buffer start address |
| bdOwned | output | 1 | Descriptor owned by the serial engine |
| wbDone | output | 1 | One-cycle writeback completion pulse |
| nakOut | output | 1 | One-cycle NAK pulse for an oversize receive |
| cfgKeep | output | 1 | Decoded keep setting |
| cfgNoInc | output | 1 | Decoded address no-increment setting |
| cfgSync | output | 1 | Decoded toggle-synchronisation enable |
| cfgStall | output | 1 | Decoded stall setting |
| cfgToggleExp | output | 1 | Expected data toggle, gated by `cfgSync` |

## Verification
The hardest case to reach is an oversize receive against a programmed count whose upper bits sit in the status byte. The NAK must leave every field and ownership intact, so a repeated completion on the same descriptor still has to behave correctly. The stimulus covers this in two ways. Directed steps hit the count exactly, one byte above it, and the full 1023 limit. Random steps then draw byte counts around the programmed value and often skip the reload, so NAKs, retries and completions on unowned descriptors chain together.

// File: rtl/bdwb_pkg.sv
package bdwb_pkg;

  typedef enum logic [1:0] {
    DIR_OUT   = 2'b00,
    DIR_IN    = 2'b01,
    DIR_SETUP = 2'b10,
    DIR_RSVD  = 2'b11
  } xferDir_e;

  typedef struct packed {
    logic load;
    logic writeBack;
    logic nak;
  } bdStrobes_t;

  localparam int OwnBit    = 7;
  localparam int ToggleBit = 6;
  localparam int PidHi     = 5;
  localparam int PidLo     = 2;

endpackage

// File: rtl/bdwb_ctrl.sv
module bdwb_ctrl
  import bdwb_pkg::*;
#(
  parameter int CountW = 10,
  localparam int HiW   = CountW - 8,
  localparam int BytesW = CountW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              descLoad,
  input  logic              xferDone,
  input  logic [1:0]        xferDir,
  input  logic [BytesW-1:0] xferBytes,
  input  logic              ownNow,
  input  logic [HiW-1:0]    cntHi,
  input  logic [7:0]        cntLo,
  output bdStrobes_t        strobes
);

  logic              isRx;
  logic              dirOk;
  logic              oversize;
  logic              live;
  logic [BytesW-1:0] limit;

  always_comb begin
    limit    = {1'b0, cntHi, cntLo};
    dirOk    = (xferDir != DIR_RSVD);
    isRx     = (xferDir == DIR_OUT) || (xferDir == DIR_SETUP);
    oversize = isRx && (xferBytes > limit);
    live     = xferDone && ownNow && dirOk && !descLoad;
    strobes.load      = descLoad;
    strobes.writeBack = live && !oversize;
    strobes.nak       = live && oversize;
  end

  // R8: a refused packet and an accepted one never coincide
  a_r8_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.writeBack && strobes.nak));

  // R9: no completion action when the engine does not own the descriptor
  a_r9_unowned: assert property (@(posedge clk) disable iff (!rstN)
    (!ownNow) |-> !(strobes.writeBack || strobes.nak));

endmodule

// File: rtl/bdwb_datapath.sv
module bdwb_datapath
  import bdwb_pkg::*;
#(
  parameter int CountW = 10,
  parameter int AddrW  = 16,
  localparam int HiW   = CountW - 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  bdStrobes_t       strobes,
  input  logic [7:0]       statIn,
  input  logic [7:0]       cntIn,
  input  logic [AddrW-1:0] addrIn,
  input  logic [3:0]       pidIn,
  input  logic [CountW-1:0] movedIn,
  output logic [7:0]       statQ,
  output logic [7:0]       cntQ,
  output logic [AddrW-1:0] addrQ,
  output logic             donePulse,
  output logic             nakPulse
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ     <= '0;
      cntQ      <= '0;
      addrQ     <= '0;
      donePulse <= 1'b0;
      nakPulse  <= 1'b0;
    end else begin
      donePulse <= strobes.writeBack;
      nakPulse  <= strobes.nak;
      if (strobes.load) begin
        statQ <= statIn;
        cntQ  <= cntIn;
        addrQ <= addrIn;
      end else if (strobes.writeBack) begin
        statQ[OwnBit]         <= 1'b0;
        statQ[PidHi:PidLo]    <= pidIn;
        statQ[HiW-1:0]        <= movedIn[CountW-1:8];
        cntQ                  <= movedIn[7:0];
      end
    end
  end

  // R3: ownership drops and the completion pulse rises on the writeback edge
  a_r3_own_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeBack |=> (!statQ[OwnBit] && donePulse));

  // R3: the completion pulse lasts a single cycle
  a_r3_one_pulse: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R4: the toggle bit survives a writeback
  a_r4_bit6_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeBack |=> (statQ[ToggleBit] == $past(statQ[ToggleBit])));

  // R8: a refused packet leaves the whole descriptor as it was
  a_r8_nak_stable: assert property (@(posedge clk) disable iff (!rstN)
    strobes.nak |=> ($stable(statQ) && $stable(cntQ) && nakPulse));

  // R12: the address only moves on a load
  a_r12_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(addrQ));

endmodule

// File: rtl/bd_status_writeback.sv
module bd_status_writeback
  import bdwb_pkg::*;
#(
  parameter int CountW = 10,
  parameter int AddrW  = 16,
  localparam int HiW    = CountW - 8,
  localparam int BytesW = CountW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              descLoad,
  input  logic [7:0]        descStatIn,
  input  logic [7:0]        descCntIn,
  input  logic [AddrW-1:0]  descAddrIn,
  input  logic              xferDone,
  input  logic [1:0]        xferDir,
  input  logic [3:0]        xferPid,
  input  logic [BytesW-1:0] xferBytes,
  output logic [7:0]        bdStat,
  output logic [7:0]        bdCnt,
  output logic [AddrW-1:0]  bdAddr,
  output logic              bdOwned,
  output logic              wbDone,
  output logic              nakOut,
  output logic              cfgKeep,
  output logic              cfgNoInc,
  output logic              cfgSync,
  output logic              cfgStall,
  output logic              cfgToggleExp
);

  bdStrobes_t strobes;
  logic [7:0] statQ;
  logic [7:0] cntQ;

  bdwb_ctrl #(.CountW(CountW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .descLoad  (descLoad),
    .xferDone  (xferDone),
    .xferDir   (xferDir),
    .xferBytes (xferBytes),
    .ownNow    (statQ[OwnBit]),
    .cntHi     (statQ[HiW-1:0]),
    .cntLo     (cntQ),
    .strobes   (strobes)
  );

  bdwb_datapath #(.CountW(CountW), .AddrW(AddrW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .statIn    (descStatIn),
    .cntIn     (descCntIn),
    .addrIn    (descAddrIn),
    .pidIn     (xferPid),
    .movedIn   (xferBytes[CountW-1:0]),
    .statQ     (statQ),
    .cntQ      (cntQ),
    .addrQ     (bdAddr),
    .donePulse (wbDone),
    .nakPulse  (nakOut)
  );

  always_comb begin
    bdStat       = statQ;
    bdCnt        = cntQ;
    bdOwned      = statQ[OwnBit];
    cfgKeep      = statQ[OwnBit] & statQ[5];
    cfgNoInc     = statQ[OwnBit] & statQ[4];
    cfgSync      = statQ[OwnBit] & statQ[3];
    cfgStall     = statQ[OwnBit] & statQ[2];
    cfgToggleExp = statQ[OwnBit] & statQ[3] & statQ[ToggleBit];
  end

  // R9: a completion on an unowned descriptor changes nothing
  a_r9_no_effect: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && !bdOwned && !descLoad) |=> ($stable(bdStat) && $stable(bdCnt) && !wbDone && !nakOut));

  // R10: decoded settings vanish once ownership is gone
  a_r10_cfg_gated: assert property (@(posedge clk) disable iff (!rstN)
    !bdOwned |-> !(cfgKeep || cfgNoInc || cfgSync || cfgStall || cfgToggleExp));

  // R2: a load shows the firmware values on the next cycle
  a_r2_load: assert property (@(posedge clk) disable iff (!rstN)
    descLoad |=> (bdStat == $past(descStatIn) && bdCnt == $past(descCntIn)));

endmodule

// File: tb/bd_status_writeback_tb.sv
module bd_status_writeback_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        descLoad = 1'b0;
  logic [7:0]  descStatIn = '0;
  logic [7:0]  descCntIn = '0;
  logic [15:0] descAddrIn = '0;
  logic        xferDone = 1'b0;
  logic [1:0]  xferDir = '0;
  logic [3:0]  xferPid = '0;
  logic [10:0] xferBytes = '0;
  logic [7:0]  bdStat;
  logic [7:0]  bdCnt;
  logic [15:0] bdAddr;
  logic        bdOwned, wbDone, nakOut;
  logic        cfgKeep, cfgNoInc, cfgSync, cfgStall, cfgToggleExp;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0]  mStat = '0;
  logic [7:0]  mCnt = '0;
  logic [15:0] mAddr = '0;

  always #2.5 clk = ~clk;

  bd_status_writeback u_dut (
    .clk(clk), .rstN(rstN), .descLoad(descLoad), .descStatIn(descStatIn),
    .descCntIn(descCntIn), .descAddrIn(descAddrIn), .xferDone(xferDone),
    .xferDir(xferDir), .xferPid(xferPid), .xferBytes(xferBytes),
    .bdStat(bdStat), .bdCnt(bdCnt), .bdAddr(bdAddr), .bdOwned(bdOwned),
    .wbDone(wbDone), .nakOut(nakOut), .cfgKeep(cfgKeep), .cfgNoInc(cfgNoInc),
    .cfgSync(cfgSync), .cfgStall(cfgStall), .cfgToggleExp(cfgToggleExp)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag, input bit eDone, input bit eNak);
    bit own;
    own = mStat[7];
    chk(tag, "status", bdStat, mStat);
    chk(tag, "count", bdCnt, mCnt);
    chk(tag, "owned", bdOwned, own);
    chk(tag, "done pulse", wbDone, eDone);
    chk(tag, "nak pulse", nakOut, eNak);
    chk("R10", "cfg", {cfgKeep, cfgNoInc, cfgSync, cfgStall},
        own ? mStat[5:2] : 4'b0);
    chk("R11", "toggle", cfgToggleExp, own & mStat[3] & mStat[6]);
    chk("R12", "address", bdAddr, mAddr);
  endtask

  task automatic step(input string tag, input bit ld, input logic [7:0] st,
                      input logic [7:0] ct, input logic [15:0] ad, input bit dn,
                      input logic [1:0] dir, input logic [3:0] pid,
                      input logic [10:0] nb);
    bit eDone = 0;
    bit eNak = 0;
    logic [10:0] lim;
    if (ld) begin
      mStat = st; mCnt = ct; mAddr = ad;
    end else if (dn && mStat[7] && dir != 2'b11) begin
      lim = {1'b0, mStat[1:0], mCnt};
      if (dir != 2'b01 && nb > lim) eNak = 1;
      else begin
        mStat = {1'b0, mStat[6], pid, nb[9:8]};
        mCnt = nb[7:0];
        eDone = 1;
      end
    end
    descLoad = ld; descStatIn = st; descCntIn = ct; descAddrIn = ad;
    xferDone = dn; xferDir = dir; xferPid = pid; xferBytes = nb;
    @(posedge clk);
    @(negedge clk);
    descLoad = 0; xferDone = 0;
    checkAll(tag, eDone, eNak);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 8'h00, 8'h00, 16'h0, 0, 2'b00, 4'h0, 11'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd1357;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    checkAll("R1", 0, 0);

    // R2 load, R6 IN writeback with R5 high bits, R4 bit6 kept
    step("R2", 1, 8'hC0 | 8'b0000_0001, 8'h10, 16'h0480, 0, 2'b00, 4'h0, 11'd0);
    step("R6", 0, 0, 0, 0, 1, 2'b01, 4'h9, 11'd300);
    idle("R3");
    // R7 OUT exact boundary
    step("R2", 1, 8'h80 | 8'h02, 8'h00, 16'h0500, 0, 2'b00, 4'h0, 11'd0);
    step("R7", 0, 0, 0, 0, 1, 2'b00, 4'h1, 11'd512);
    // R8 one byte over, then retry accepted
    step("R2", 1, 8'h80, 8'h40, 16'h0600, 0, 2'b00, 4'h0, 11'd0);
    step("R8", 0, 0, 0, 0, 1, 2'b00, 4'h1, 11'd65);
    idle("R8");
    step("R7", 0, 0, 0, 0, 1, 2'b10, 4'hD, 11'd64);
    // R9 completion after ownership returned, and reserved direction
    step("R9", 0, 0, 0, 0, 1, 2'b01, 4'h9, 11'd5);
    step("R2", 1, 8'hFF, 8'hFF, 16'hFFFF, 0, 2'b00, 4'h0, 11'd0);
    step("R9", 0, 0, 0, 0, 1, 2'b11, 4'h9, 11'd5);
    // R5 full 1023 and 1024 refused; R10/R11 decode while owned
    step("R8", 0, 0, 0, 0, 1, 2'b00, 4'h1, 11'd1024);
    step("R5", 0, 0, 0, 0, 1, 2'b00, 4'h1, 11'd1023);
    // R11 toggle masked when sync off; R12 low address
    step("R11", 1, 8'hC0, 8'h00, 16'h0003, 0, 2'b00, 4'h0, 11'd0);
    step("R7", 0, 0, 0, 0, 1, 2'b00, 4'h1, 11'd0);
    // R2 load wins over a same-cycle completion
    step("R2", 1, 8'h88, 8'h05, 16'h0410, 1, 2'b01, 4'h9, 11'd3);

    for (int i = 0; i < 400; i++) begin
      bit ld;
      logic [7:0] st;
      logic [7:0] ct;
      logic [10:0] nb;
      ld = ($urandom % 3) == 0;
      st = 8'($urandom);
      if (($urandom % 4) != 0) st[7] = 1'b1;
      ct = 8'($urandom);
      if (ld) step("R2", 1, st, ct, 16'($urandom), 0, 2'b00, 4'h0, 11'd0);
      nb = 11'({mStat[1:0], mCnt}) + 11'($urandom % 5) - 11'd2;
      if (($urandom % 4) == 0) nb = 11'($urandom);
      if (($urandom % 5) == 0) idle("R9");
      step("R7", 0, 0, 0, 0, 1, 2'($urandom), 4'($urandom), nb);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule